// File: doc/BRIEF.md
# Subvector Element Swizzle Engine

This block runs one swizzle operation over a region of a byte-addressable register file. The region holds a vector of `vl` short subvectors. Each source subvector has `src_len` elements. For every subvector the engine builds a destination subvector of `dst_len` elements. Destination lane j receives the source element whose index is the constant selector for lane j, and that selector comes with the operation. Source and destination lengths are independent, so the same engine widens, narrows, duplicates or permutes elements. With `dst_len` = 1 it pulls one element out of every subvector.

The engine handles one subvector per clock. In a single cycle it reads the whole source subvector through a combinational read port and issues one strobed write of the destination subvector. Each subvector therefore reads memory only after the previous subvector's write has landed. When the operation has started, has zero length or is rejected, one `done` pulse closes it. An operation with an illegal configuration writes nothing and raises `err` together with `done`.

Top module: `swz_engine`

## Requirements
- R1: Out of reset, `busy`, `done`, `err` and `wr_en` are all low.
- R2: For subvector i and destination lane j < `dst_len`, the element at destination index i*`dst_len`+j becomes the source element at index i*`src_len`+sel[j]. Lane j's selector is `sel[2j+1:2j]`. Element index k is found at byte `base + k*size`, and multi-byte elements are little-endian.
- R3: `elem_type` code 0 selects 8-bit elements, code 1 selects 16-bit elements and code 2 selects 32-bit elements. All indexing uses that element size.
- R4: `src_len` and `dst_len` are each independent in 1..4. A selector value may repeat across lanes, which copies one source element into several destination lanes.
- R5: With `dst_len` = 1, the single selector extracts one element from each source subvector into a packed destination array.
- R6: After `start` is accepted, `wr_en` is high for exactly `vl` consecutive cycles, beginning the cycle after `start`. `done` is high for exactly one cycle, directly after the last write cycle.
- R7: With `vl` = 0, `done` pulses the cycle after `start` and no write occurs.
- R8: The operation is illegal if any selector of a lane below `dst_len` is greater than or equal to `src_len`, if either length is 0 or above 4, or if `elem_type` is 3. An illegal operation performs no write and pulses `done` with `err` high the cycle after `start`. Selectors of lanes at or above `dst_len` are ignored.
- R9: Subvectors are processed in ascending order. All source elements of a subvector are captured before its write, so overlapping or identical source and destination regions give the result of a per-subvector sequential copy.
- R10: A `start` that arrives while `busy` is high is ignored.
- R11: Each write enables exactly the first `dst_len`*size bytes of `wr_data` through `wr_strb`, and no other byte of the register file changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch an operation with the operand inputs |
| src_base | input | AW | Byte address of source element 0 |
| dst_base | input | AW | Byte address of destination element 0 |
| src_len | input | 3 | Elements per source subvector |
| dst_len | input | 3 | Elements per destination subvector |
| elem_type | input | 2 | Element size code (0: 8, 1: 16, 2: 32 bits) |
| sel | input | 2*MAXSUB | Per-lane source selectors, lane j at bits 2j+1:2j |
| vl | input | VLW | Number of subvectors |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Illegal operation, valid with `done` |
| rd_addr | output | AW | Byte address of the current source subvector |
| rd_data | input | 32*MAXSUB | Bytes from `rd_addr` upward, byte b at bits 8b+7:8b |
| wr_en | output | 1 | Write the current destination subvector |
| wr_addr | output | AW | Byte address of the current destination subvector |
| wr_data | output | 32*MAXSUB | Destination bytes, byte b at bits 8b+7:8b |
| wr_strb | output | 4*MAXSUB | Per-byte write enables |

## Verification
The swizzle runs over every element size, every pair of source and destination lengths from 1 to 4, and three selector patterns: a reversal, a strided pattern with repeats, and an identity-like pattern. A wrong lane index, a wrong element width or a wrong stride therefore shows up as different memory contents. Lanes above `dst_len` carry the out-of-range selector 3, which exposes any decoder that checks or writes unused lanes. Directed cases cover the widening example [0,0,2,1], extraction, zero length, a maximum-length vector, every illegal class, a restart while busy, and in-place and shifted overlaps. The overlap cases separate sequential per-subvector semantics from read-ahead behaviour.

// File: rtl/swz_pkg.sv
package swz_pkg;

   typedef enum logic [1:0] {
      ET_U8   = 2'd0,
      ET_U16  = 2'd1,
      ET_U32  = 2'd2,
      ET_RSVD = 2'd3
   } elem_e;

   // log2 of the element size in bytes
   function automatic logic [1:0] size_log2(elem_e t);
      case (t)
         ET_U16:  return 2'd1;
         ET_U32:  return 2'd2;
         default: return 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/swz_legal.sv
module swz_legal
   import swz_pkg::*;
#(
   parameter int MAXSUB = 4,
   parameter int LENW   = $clog2(MAXSUB + 1),
   parameter int SELW   = (MAXSUB > 1) ? $clog2(MAXSUB) : 1
) (
   input  logic [LENW-1:0]        src_len,
   input  logic [LENW-1:0]        dst_len,
   input  elem_e                  etype,
   input  logic [MAXSUB*SELW-1:0] sel,
   output logic                   ok
);

   logic [MAXSUB-1:0] lane_ok;
   logic              len_ok;

   // Lanes past dst_len are don't-care; active lanes must stay inside the source subvector
   for (genvar j = 0; j < MAXSUB; j++) begin : g_lane
      assign lane_ok[j] = (LENW'(j) >= dst_len) ||
                          (LENW'(sel[j*SELW +: SELW]) < src_len);
   end

   assign len_ok = (src_len != '0) && (src_len <= LENW'(MAXSUB)) &&
                   (dst_len != '0) && (dst_len <= LENW'(MAXSUB));

   assign ok = (&lane_ok) && len_ok && (etype != ET_RSVD);

endmodule

// File: rtl/swz_lanes.sv
module swz_lanes
   import swz_pkg::*;
#(
   parameter int MAXSUB = 4,
   parameter int LENW   = $clog2(MAXSUB + 1),
   parameter int SELW   = (MAXSUB > 1) ? $clog2(MAXSUB) : 1,
   parameter int DW     = 32 * MAXSUB,
   parameter int BW     = DW / 8
) (
   input  logic [DW-1:0]          rd_data,
   input  logic [MAXSUB*SELW-1:0] sel,
   input  elem_e                  etype,
   input  logic [LENW-1:0]        dst_len,
   output logic [DW-1:0]          wr_data,
   output logic [BW-1:0]          wr_strb
);

   logic [MAXSUB*8-1:0]  pack8;
   logic [MAXSUB*16-1:0] pack16;
   logic [MAXSUB*32-1:0] pack32;

   // One selector mux per destination lane, one width variant per element size
   for (genvar j = 0; j < MAXSUB; j++) begin : g_lane
      logic [SELW-1:0] idx;
      assign idx = sel[j*SELW +: SELW];
      assign pack8 [j*8  +: 8]  = rd_data[int'(idx)*8  +: 8];
      assign pack16[j*16 +: 16] = rd_data[int'(idx)*16 +: 16];
      assign pack32[j*32 +: 32] = rd_data[int'(idx)*32 +: 32];
   end

   always_comb begin
      case (etype)
         ET_U8:   wr_data = DW'(pack8);
         ET_U16:  wr_data = DW'(pack16);
         default: wr_data = DW'(pack32);
      endcase
   end

   int nbytes;
   always_comb begin
      nbytes = int'(dst_len) << size_log2(etype);
      for (int b = 0; b < BW; b++) wr_strb[b] = (b < nbytes);
   end

endmodule

// File: rtl/swz_engine.sv
module swz_engine
   import swz_pkg::*;
#(
   parameter int AW     = 12,
   parameter int VLW    = 6,
   parameter int MAXSUB = 4,
   localparam int LENW  = $clog2(MAXSUB + 1),
   localparam int SELW  = (MAXSUB > 1) ? $clog2(MAXSUB) : 1,
   localparam int DW    = 32 * MAXSUB,
   localparam int BW    = DW / 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [AW-1:0]          src_base,
   input  logic [AW-1:0]          dst_base,
   input  logic [LENW-1:0]        src_len,
   input  logic [LENW-1:0]        dst_len,
   input  logic [1:0]             elem_type,
   input  logic [MAXSUB*SELW-1:0] sel,
   input  logic [VLW-1:0]         vl,
   output logic                   busy,
   output logic                   done,
   output logic                   err,
   output logic [AW-1:0]          rd_addr,
   input  logic [DW-1:0]          rd_data,
   output logic                   wr_en,
   output logic [AW-1:0]          wr_addr,
   output logic [DW-1:0]          wr_data,
   output logic [BW-1:0]          wr_strb
);

   if (MAXSUB < 1 || MAXSUB > 4) begin : g_bad_maxsub
      $error("swz_engine: MAXSUB must lie in 1..4");
   end
   if (AW < 8 || VLW < 1) begin : g_bad_width
      $error("swz_engine: AW must be at least 8 and VLW at least 1");
   end

   elem_e                  et_in;
   logic                   legal;
   logic                   launch;

   logic                   busy_q, done_q, err_q;
   logic [VLW-1:0]         cnt_q;
   logic [AW-1:0]          rd_ptr_q, wr_ptr_q;
   logic [AW-1:0]          src_step_q, dst_step_q;
   logic [MAXSUB*SELW-1:0] sel_q;
   logic [LENW-1:0]        dst_len_q;
   elem_e                  et_q;

   assign et_in  = elem_e'(elem_type);
   assign launch = start && !busy_q;

   swz_legal #(.MAXSUB(MAXSUB), .LENW(LENW), .SELW(SELW)) i_legal (
      .src_len (src_len),
      .dst_len (dst_len),
      .etype   (et_in),
      .sel     (sel),
      .ok      (legal)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         done_q     <= 1'b0;
         err_q      <= 1'b0;
         cnt_q      <= '0;
         rd_ptr_q   <= '0;
         wr_ptr_q   <= '0;
         src_step_q <= '0;
         dst_step_q <= '0;
         sel_q      <= '0;
         dst_len_q  <= '0;
         et_q       <= ET_U8;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         if (launch) begin
            sel_q      <= sel;
            dst_len_q  <= dst_len;
            et_q       <= et_in;
            src_step_q <= AW'(src_len) << size_log2(et_in);
            dst_step_q <= AW'(dst_len) << size_log2(et_in);
            rd_ptr_q   <= src_base;
            wr_ptr_q   <= dst_base;
            if (!legal) begin
               done_q <= 1'b1;
               err_q  <= 1'b1;
            end else if (vl == '0) begin
               done_q <= 1'b1;
            end else begin
               busy_q <= 1'b1;
               cnt_q  <= vl;
            end
         end else if (busy_q) begin
            rd_ptr_q <= rd_ptr_q + src_step_q;
            wr_ptr_q <= wr_ptr_q + dst_step_q;
            cnt_q    <= cnt_q - 1'b1;
            if (cnt_q == VLW'(1)) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   // Read and write of one subvector share a cycle: source data is sampled at the write edge
   swz_lanes #(.MAXSUB(MAXSUB), .LENW(LENW), .SELW(SELW), .DW(DW), .BW(BW)) i_lanes (
      .rd_data (rd_data),
      .sel     (sel_q),
      .etype   (et_q),
      .dst_len (dst_len_q),
      .wr_data (wr_data),
      .wr_strb (wr_strb)
   );

   assign busy    = busy_q;
   assign done    = done_q;
   assign err     = err_q;
   assign wr_en   = busy_q;
   assign rd_addr = rd_ptr_q;
   assign wr_addr = wr_ptr_q;

   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_busy_launch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
   assert_write_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (wr_en || done));
   assert_illegal_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |-> !$past(wr_en));
   assert_restart_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (busy || (done && !err)));
   assert_strobe_present_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> wr_strb[0]);

endmodule

// File: tb/test_swz_engine.sv
module test_swz_engine;

   localparam int AW = 12, VLW = 6, MAXSUB = 4;
   localparam int DW = 32 * MAXSUB, BW = DW / 8, MSZ = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] src_base = '0, dst_base = '0;
   logic [2:0]    src_len = 3'd1, dst_len = 3'd1;
   logic [1:0]    elem_type = 2'd0;
   logic [7:0]    sel = '0;
   logic [VLW-1:0] vl = '0;
   logic          busy, done, err, wr_en;
   logic [AW-1:0] rd_addr, wr_addr;
   logic [DW-1:0] rd_data, wr_data;
   logic [BW-1:0] wr_strb;

   logic [7:0] mem  [MSZ];
   logic [7:0] refm [MSZ];

   int vectors = 0;
   int fails   = 0;

   always #4 clk = ~clk;

   swz_engine #(.AW(AW), .VLW(VLW), .MAXSUB(MAXSUB)) i_swz_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .src_base(src_base), .dst_base(dst_base),
      .src_len(src_len), .dst_len(dst_len), .elem_type(elem_type), .sel(sel), .vl(vl),
      .busy(busy), .done(done), .err(err), .rd_addr(rd_addr), .rd_data(rd_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb)
   );

   // Register-file model: combinational read, strobed write at the clock edge
   always_comb
      for (int b = 0; b < BW; b++) rd_data[b*8 +: 8] = mem[rd_addr + AW'(b)];

   always @(posedge clk)
      if (wr_en)
         for (int b = 0; b < BW; b++)
            if (wr_strb[b]) mem[wr_addr + AW'(b)] <= wr_data[b*8 +: 8];

   task automatic check(bit ok, string req, string what, int act, int exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic fill(int seed);
      for (int a = 0; a < MSZ; a++) mem[a] = 8'(a * 29 + seed * 13 + (a >> 5));
   endtask

   function automatic int unsigned rget(int addr, int esz);
      int unsigned v = 0;
      for (int b = 0; b < esz; b++) v |= int'(refm[(addr + b) % MSZ]) << (8 * b);
      return v;
   endfunction

   task automatic rput(int addr, int esz, int unsigned v);
      for (int b = 0; b < esz; b++) refm[(addr + b) % MSZ] = 8'(v >> (8 * b));
   endtask

   task automatic run_op(string req, int sb, int db, int s, int d, int et,
                         logic [7:0] sv, int n, bit exp_err, bit poke);
      int unsigned tmp [4];
      int esz, cyc, nw, done_cyc, bad;
      bit got_err;
      for (int a = 0; a < MSZ; a++) refm[a] = mem[a];
      if (!exp_err) begin
         esz = 1 << et;
         for (int i = 0; i < n; i++) begin
            for (int k = 0; k < s; k++) tmp[k] = rget(sb + (i * s + k) * esz, esz);
            for (int j = 0; j < d; j++) rput(db + (i * d + j) * esz, esz, tmp[sv[2*j +: 2]]);
         end
      end
      @(negedge clk);
      src_base = AW'(sb); dst_base = AW'(db); src_len = 3'(s); dst_len = 3'(d);
      elem_type = 2'(et); sel = sv; vl = VLW'(n); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         start = 1'b1; dst_base = AW'(db + 64); sel = 8'h00; vl = VLW'(1);
      end
      cyc = 1; nw = 0; done_cyc = -1; got_err = 1'b0;
      while (cyc < 200) begin
         if (wr_en) nw++;
         if (done) begin done_cyc = cyc; got_err = err; break; end
         @(negedge clk);
         start = 1'b0;
         cyc++;
      end
      check(nw == (exp_err ? 0 : n), exp_err ? "R8" : "R6", "write cycles", nw, exp_err ? 0 : n);
      check(done_cyc == (exp_err ? 1 : n + 1), (n == 0) ? "R7" : "R6", "done cycle",
            done_cyc, exp_err ? 1 : n + 1);
      check(got_err == exp_err, "R8", "err flag", int'(got_err), int'(exp_err));
      bad = -1;
      for (int a = 0; a < MSZ; a++) if (bad < 0 && mem[a] !== refm[a]) bad = a;
      if (bad < 0) check(1'b1, req, "memory", 0, 0);
      else check(1'b0, req, $sformatf("memory byte %0d", bad), int'(mem[bad]), int'(refm[bad]));
      @(negedge clk);
      check(!done, "R6", "done after pulse", int'(done), 0);
   endtask

   initial begin
      #(8 * 150000);
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      fill(0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done && !err && !wr_en, "R1", "reset outputs",
            {busy, done, err, wr_en}, 0);

      // R2 R4: widening example with repeated selector [0,0,2,1], 8-bit
      fill(1); run_op("R2", 40, 900, 3, 4, 0, 8'h60, 5, 1'b0, 1'b0);
      // R5: extraction of element 2 from 32-bit quads, unused lanes hold 3
      fill(2); run_op("R5", 100, 1500, 4, 1, 2, 8'hFE, 5, 1'b0, 1'b0);
      // R7: zero length
      fill(3); run_op("R7", 10, 20, 2, 2, 1, 8'h04, 0, 1'b0, 1'b0);
      // R8: illegal selector in an active lane, illegal type, illegal lengths
      fill(4); run_op("R8", 10, 700, 2, 2, 0, 8'h0C, 4, 1'b1, 1'b0);
      fill(5); run_op("R8", 10, 700, 2, 2, 3, 8'h04, 4, 1'b1, 1'b0);
      fill(6); run_op("R8", 10, 700, 0, 2, 0, 8'h00, 4, 1'b1, 1'b0);
      fill(7); run_op("R8", 10, 700, 5, 2, 0, 8'h04, 4, 1'b1, 1'b0);
      fill(8); run_op("R8", 10, 700, 2, 0, 1, 8'h00, 4, 1'b1, 1'b0);
      // R10: start while busy
      fill(9); run_op("R10", 200, 1200, 3, 3, 1, 8'h06, 6, 1'b0, 1'b1);
      // R9: in-place reversal and shifted overlap
      fill(10); run_op("R9", 256, 256, 3, 3, 1, 8'h06, 6, 1'b0, 1'b0);
      fill(11); run_op("R9", 512, 514, 2, 2, 1, 8'h01, 5, 1'b0, 1'b0);
      // R6: maximum length, 32-bit, full quads
      fill(12); run_op("R6", 0, 2048, 4, 4, 2, 8'h1B, 63, 1'b0, 1'b0);

      // R2 R3 R4 R11: sweep of sizes, lengths and selector patterns
      for (int et = 0; et < 3; et++)
         for (int s = 1; s <= 4; s++)
            for (int d = 1; d <= 4; d++)
               for (int pat = 0; pat < 3; pat++) begin
                  logic [7:0] sv;
                  int n;
                  for (int j = 0; j < 4; j++) begin
                     int v;
                     if (j >= d)        v = 3;
                     else if (pat == 0) v = (s - 1 - (j % s));
                     else if (pat == 1) v = (j * 3 + 1) % s;
                     else               v = j % s;
                     sv[2*j +: 2] = 2'(v);
                  end
                  n = 1 + ((et * 7 + s * 3 + d + pat) % 6);
                  fill(et * 50 + s * 9 + d * 3 + pat);
                  run_op((et == 0) ? "R11" : "R3", 16 + et * 8, 1024 + s * 20 + d,
                         s, d, et, sv, n, 1'b0, 1'b0);
               end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule